// File: doc/BRIEF.md
# Configurable TDM Serial Audio Frame Generator

This block is the transmit sequencer of a master-mode serial audio port. On every pulse of a bit-clock enable it advances one bit through a frame of one to sixteen time slots. It shifts parallel samples out MSB first on a serial data line, drives a frame sync and marks the bits of enabled slots. The frame layout comes from a small configuration set: the wire format (I2S, left-justified, right-justified, or the two short-sync PCM variants), slot count, slot size, data size, slot-enable mask, sync polarity and mono duplication. From these the block derives frame length, sync width, sync timing and first-bit offset.

Samples arrive on a valid/ready stream and wait in a one-entry holding register. A one-cycle request pulse marks each slot start that takes a sample. The configuration is captured when `run` rises and stays fixed until `run` falls. A configuration that cannot be laid out is flagged, and the block does not start.

Top module: `tdm_frame_gen`

## Requirements
- R1: A frame lasts slot width × slot count bit-clock ticks, and the sync pattern and slot order repeat with that period.
- R2: `cfg_slots_m1` holds the slot count minus one, so 0..15 gives 1..16 slots.
- R3: Slot size code 0 makes the slot width equal to the data width, code 1 gives 16 bits and code 2 gives 32 bits. Code 3 is invalid.
- R4: Data size codes are 2=8, 3=10, 4=16, 5=20, 6=24 and 7=32 bits. Codes 0 and 1 are invalid. Sample bits [dw-1:0] leave MSB first, and all other bits of the slot are low.
- R5: Format codes are 0=I2S, 1=left-justified, 2=right-justified, 3=PCM early sync and 4=PCM late sync. Codes 5 to 7 are invalid. The sync is active for half the frame in formats 0-2 and for one tick in formats 3-4. `cfg_fs_inv`=1 inverts the `fs` level while running.
- R6: In formats 0 and 3 the sync becomes active one tick before the first bit of slot 0. In formats 1, 2 and 4 it becomes active on that bit.
- R7: In format 2 the first data bit of each slot is delayed by slot width minus data width.
- R8: A data width larger than the slot width, or any invalid code, raises `cfg_err`. While `cfg_err` is high, `run` does not start the block: `s_ready`, `fs`, `sdo`, `slot_act` and `req` stay low.
- R9: A zero `cfg_slot_en` enables every configured slot. Otherwise bit n enables slot n, and bits at or above the slot count are ignored.
- R10: A disabled slot drives `sdo` and `slot_act` low and takes no sample.
- R11: With two slots and `cfg_mono`=1, slot 1 repeats the sample taken in slot 0 and takes none of its own.
- R12: Outputs change only in the cycle after a tick. `req` is a one-cycle pulse at each sample-taking slot start. The holding register takes one sample and then drops `s_ready` until that sample is used.
- R13: The first tick after start is a lead-in bit with `sdo` and `slot_act` low and the sync at its last-bit-of-frame level. Frame bit 0 follows on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start (high) and stop (low) level |
| bclk_en | input | 1 | One-cycle pulse per serial bit |
| cfg_fmt | input | 3 | Wire format code |
| cfg_slots_m1 | input | 4 | Slot count minus one |
| cfg_slot_sz | input | 2 | Slot size code |
| cfg_data_sz | input | 3 | Data size code |
| cfg_slot_en | input | 16 | Per-slot enable mask |
| cfg_fs_inv | input | 1 | Frame sync polarity invert |
| cfg_mono | input | 1 | Duplicate slot 0 sample into slot 1 |
| s_data | input | 32 | Sample, right-aligned |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Holding register can take a sample |
| sdo | output | 1 | Serial data |
| fs | output | 1 | Frame sync |
| slot_act | output | 1 | Current bit lies in an enabled slot |
| req | output | 1 | Sample-taken pulse |
| cfg_err | output | 1 | Configuration cannot be laid out |

## Verification
Every format is run over two full frames, and every tick is compared with a model built from the requirements. Sync width and early or late timing tell the five formats apart. The left-justified case uses a 10-bit slot derived from the data width, while the right-justified case puts 8 bits in a 16-bit slot so that the offset shows. A sparse mask with stray high bits, a zero mask over eight slots and a sixteen-slot frame separate mask handling from slot counting. The mono case shows a repeated sample in slot 1 with a single sample taken per frame. Invalid sizes and format codes are checked for a block that never leaves idle.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int TDM_MAX_SLOTS = 16;
    localparam int SMP_W         = 32;
    localparam int SLOT_IDX_W    = $clog2(TDM_MAX_SLOTS);
    localparam int BIT_W         = $clog2(SMP_W) + 1;
    localparam int SMP_IDX_W     = $clog2(SMP_W);
    localparam int POS_W         = $clog2(TDM_MAX_SLOTS * SMP_W);

    typedef enum logic [2:0] {
        FMT_I2S       = 3'd0,
        FMT_LEFT      = 3'd1,
        FMT_RIGHT     = 3'd2,
        FMT_PCM_EARLY = 3'd3,
        FMT_PCM_LATE  = 3'd4
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } run_st_e;

    typedef struct packed {
        logic [BIT_W-1:0]         sw;
        logic [BIT_W-1:0]         dw;
        logic [BIT_W-1:0]         off;
        logic [SLOT_IDX_W-1:0]    nsl_m1;
        logic [TDM_MAX_SLOTS-1:0] mask;
        logic [POS_W-1:0]         fl_m1;
        logic [POS_W-1:0]         act_m1;
        logic                     early;
        logic                     inv;
        logic                     dup;
    } tdm_cfg_t;

    function automatic logic tdm_fs_level(
        input logic [POS_W-1:0] pos,
        input logic [POS_W-1:0] fl_m1,
        input logic [POS_W-1:0] act_m1,
        input logic             early,
        input logic             inv
    );
        logic [POS_W-1:0] nxt;
        logic             hit;
        nxt = (pos == fl_m1) ? '0 : pos + 1'b1;
        hit = early ? (nxt <= act_m1) : (pos <= act_m1);
        return hit ^ inv;
    endfunction

endpackage

// File: rtl/tdm_cfg_decode.sv
module tdm_cfg_decode
    import tdm_pkg::*;
(
    input  logic [2:0]               fmt_raw,
    input  logic [SLOT_IDX_W-1:0]    slots_m1,
    input  logic [1:0]               slot_sz,
    input  logic [2:0]               data_sz,
    input  logic [TDM_MAX_SLOTS-1:0] slot_en,
    input  logic                     fs_inv,
    input  logic                     mono,
    output tdm_cfg_t                 cfg,
    output logic                     err
);
    logic [TDM_MAX_SLOTS-1:0] nsl_mask;
    logic [SLOT_IDX_W:0]      nsl;
    logic [POS_W:0]           fl_full;
    logic [BIT_W-1:0]         dw, sw;
    logic                     bad_dw, bad_sw, bad_fmt, pcm;

    for (genvar g = 0; g < TDM_MAX_SLOTS; g++) begin : g_slot_mask
        assign nsl_mask[g] = (SLOT_IDX_W'(g) <= slots_m1);
    end

    always_comb begin
        bad_dw = 1'b0;
        unique case (data_sz)
            3'd2:    dw = BIT_W'(8);
            3'd3:    dw = BIT_W'(10);
            3'd4:    dw = BIT_W'(16);
            3'd5:    dw = BIT_W'(20);
            3'd6:    dw = BIT_W'(24);
            3'd7:    dw = BIT_W'(32);
            default: begin dw = '0; bad_dw = 1'b1; end
        endcase

        bad_sw = 1'b0;
        unique case (slot_sz)
            2'd0:    sw = dw;
            2'd1:    sw = BIT_W'(16);
            2'd2:    sw = BIT_W'(32);
            default: begin sw = '0; bad_sw = 1'b1; end
        endcase

        bad_fmt = (fmt_raw > 3'(FMT_PCM_LATE));
        pcm     = (fmt_raw == 3'(FMT_PCM_EARLY)) || (fmt_raw == 3'(FMT_PCM_LATE));
        err     = bad_dw || bad_sw || bad_fmt || (dw > sw);

        nsl     = {1'b0, slots_m1} + 1'b1;
        fl_full = (POS_W+1)'(sw) * (POS_W+1)'(nsl);

        cfg.sw     = sw;
        cfg.dw     = dw;
        cfg.off    = (fmt_raw == 3'(FMT_RIGHT)) ? (sw - dw) : '0;
        cfg.nsl_m1 = slots_m1;
        cfg.mask   = (slot_en == '0) ? nsl_mask : (slot_en & nsl_mask);
        cfg.fl_m1  = POS_W'(fl_full - 1'b1);
        cfg.act_m1 = pcm ? '0 : (cfg.fl_m1 >> 1);
        cfg.early  = (fmt_raw == 3'(FMT_I2S)) || (fmt_raw == 3'(FMT_PCM_EARLY));
        cfg.inv    = fs_inv;
        cfg.dup    = mono && (slots_m1 == SLOT_IDX_W'(1));
    end
endmodule

// File: rtl/tdm_sample_hold.sv
module tdm_sample_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [W-1:0] s_data,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic         take,
    output logic [W-1:0] out_data,
    output logic         out_valid
);
    typedef struct packed {
        logic         v;
        logic [W-1:0] d;
    } hold_t;

    hold_t q, d;

    assign s_ready   = !q.v && !flush;
    assign out_data  = q.d;
    assign out_valid = q.v;

    always_comb begin
        d = q;
        if (flush) begin
            d.v = 1'b0;
        end else begin
            if (take) d.v = 1'b0;
            if (s_valid && s_ready) begin
                d.v = 1'b1;
                d.d = s_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tdm_frame_gen.sv
module tdm_frame_gen
    import tdm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     bclk_en,
    input  logic [2:0]               cfg_fmt,
    input  logic [SLOT_IDX_W-1:0]    cfg_slots_m1,
    input  logic [1:0]               cfg_slot_sz,
    input  logic [2:0]               cfg_data_sz,
    input  logic [TDM_MAX_SLOTS-1:0] cfg_slot_en,
    input  logic                     cfg_fs_inv,
    input  logic                     cfg_mono,
    input  logic [SMP_W-1:0]         s_data,
    input  logic                     s_valid,
    output logic                     s_ready,
    output logic                     sdo,
    output logic                     fs,
    output logic                     slot_act,
    output logic                     req,
    output logic                     cfg_err
);
    typedef struct packed {
        run_st_e               st;
        logic [SLOT_IDX_W-1:0] slot;
        logic [BIT_W-1:0]      bitc;
        logic [POS_W-1:0]      pos;
        logic                  lead;
        logic [SMP_W-1:0]      smp;
        logic                  sdo;
        logic                  fs;
        logic                  act;
        logic                  req;
        tdm_cfg_t              cfg;
    } seq_t;

    seq_t q, d;

    tdm_cfg_t         dec_cfg;
    logic             dec_err;
    logic             take;
    logic [SMP_W-1:0] hold_d;
    logic             hold_v;

    tdm_cfg_decode u_dec (
        .fmt_raw  (cfg_fmt),
        .slots_m1 (cfg_slots_m1),
        .slot_sz  (cfg_slot_sz),
        .data_sz  (cfg_data_sz),
        .slot_en  (cfg_slot_en),
        .fs_inv   (cfg_fs_inv),
        .mono     (cfg_mono),
        .cfg      (dec_cfg),
        .err      (dec_err)
    );

    tdm_sample_hold #(.W(SMP_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (q.st == ST_IDLE),
        .s_data    (s_data),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .take      (take),
        .out_data  (hold_d),
        .out_valid (hold_v)
    );

    logic [SLOT_IDX_W-1:0] slot_n;
    logic [BIT_W-1:0]      bit_n;
    logic [BIT_W-1:0]      idx;
    logic [POS_W-1:0]      pos_n;
    logic                  lead_n;
    logic [SMP_W-1:0]      smp_n;
    logic                  en_n;
    logic                  win;

    always_comb begin
        d      = q;
        d.req  = 1'b0;
        take   = 1'b0;
        slot_n = q.slot;
        bit_n  = q.bitc;
        pos_n  = q.pos;
        lead_n = q.lead;
        smp_n  = q.smp;
        en_n   = 1'b0;
        win    = 1'b0;
        idx    = '0;
        unique case (q.st)
            ST_IDLE: begin
                d.sdo  = 1'b0;
                d.fs   = 1'b0;
                d.act  = 1'b0;
                d.lead = 1'b0;
                if (run && !dec_err) begin
                    d.st  = ST_ARMED;
                    d.cfg = dec_cfg;
                end
            end
            default: begin
                if (!run) begin
                    d.st   = ST_IDLE;
                    d.sdo  = 1'b0;
                    d.fs   = 1'b0;
                    d.act  = 1'b0;
                    d.lead = 1'b0;
                end else if (bclk_en) begin
                    if (q.st == ST_ARMED) begin
                        slot_n = q.cfg.nsl_m1;
                        bit_n  = q.cfg.sw - 1'b1;
                        pos_n  = q.cfg.fl_m1;
                        lead_n = 1'b1;
                    end else begin
                        lead_n = 1'b0;
                        pos_n  = (q.pos == q.cfg.fl_m1) ? '0 : q.pos + 1'b1;
                        if (q.bitc == q.cfg.sw - 1'b1) begin
                            bit_n  = '0;
                            slot_n = (q.slot == q.cfg.nsl_m1) ? '0 : q.slot + 1'b1;
                        end else begin
                            bit_n  = q.bitc + 1'b1;
                        end
                    end

                    en_n = q.cfg.mask[slot_n] && !lead_n;
                    if (en_n && (bit_n == '0) &&
                        !(q.cfg.dup && (slot_n == SLOT_IDX_W'(1)))) begin
                        take  = 1'b1;
                        smp_n = hold_v ? hold_d : '0;
                        d.req = 1'b1;
                    end

                    win = (bit_n >= q.cfg.off) && (bit_n < q.cfg.off + q.cfg.dw);
                    idx = q.cfg.dw - 1'b1 - (bit_n - q.cfg.off);

                    d.st   = ST_RUN;
                    d.slot = slot_n;
                    d.bitc = bit_n;
                    d.pos  = pos_n;
                    d.lead = lead_n;
                    d.smp  = smp_n;
                    d.sdo  = en_n && win && smp_n[idx[SMP_IDX_W-1:0]];
                    d.act  = en_n;
                    d.fs   = tdm_fs_level(pos_n, q.cfg.fl_m1, q.cfg.act_m1,
                                          q.cfg.early, q.cfg.inv);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo      = q.sdo;
    assign fs       = q.fs;
    assign slot_act = q.act;
    assign req      = q.req;
    assign cfg_err  = dec_err;
endmodule

// File: rtl/tdm_frame_gen_chk.sv
module tdm_frame_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic bclk_en,
    input logic s_valid,
    input logic s_ready,
    input logic sdo,
    input logic fs,
    input logic slot_act,
    input logic req
);
    // R12: outputs hold their value unless a tick or a stop was seen
    assert_quiet_between_ticks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$past(bclk_en)) |-> ($stable(sdo) && $stable(fs) && $stable(slot_act)));

    // R10: a disabled slot keeps the data line low
    assert_dark_disabled_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_act |-> !sdo);

    // R10: samples are taken only by enabled slots
    assert_req_in_enabled_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> slot_act);

    // R12: one-entry holding register
    assert_single_entry_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !s_ready);

    // R12: request is a single-cycle pulse
    assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
endmodule

bind tdm_frame_gen tdm_frame_gen_chk u_chk (.*);

// File: tb/tb_tdm_frame_gen.sv
module tb_tdm_frame_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        bclk_en = 1'b0;
    logic [2:0]  cfg_fmt = '0;
    logic [3:0]  cfg_slots_m1 = '0;
    logic [1:0]  cfg_slot_sz = '0;
    logic [2:0]  cfg_data_sz = 3'd4;
    logic [15:0] cfg_slot_en = '0;
    logic        cfg_fs_inv = 1'b0;
    logic        cfg_mono = 1'b0;
    logic [31:0] s_data;
    logic        s_valid;
    logic        s_ready, sdo, fs, slot_act, req, cfg_err;

    int checks = 0;
    int fails  = 0;
    int src_idx;
    logic src_on = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    tdm_frame_gen dut (.*);

    function automatic logic [31:0] sample_of(input int i);
        return 32'h6B1D_42E7 ^ (32'(i) * 32'h9E37_79B9);
    endfunction

    assign s_valid = src_on && (src_idx < 64);
    assign s_data  = sample_of(src_idx);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_idx <= 0;
        else if (s_valid && s_ready) src_idx <= src_idx + 1;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        run = 1'b0; bclk_en = 1'b0; src_on = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_case(input string tag, input int fmt, input int sm1, input int ssz,
                            input int dsz, input logic [15:0] en, input logic inv,
                            input logic mono, input int nfr);
        int dw, sw, fl, act_len, off, k, p, s, b;
        logic early;
        logic [15:0] em, all;
        logic [31:0] cur;
        logic [3:0] got, exp;
        logic hit, e_en, e_sdo, e_req;
        do_reset();
        cfg_fmt = 3'(fmt); cfg_slots_m1 = 4'(sm1); cfg_slot_sz = 2'(ssz);
        cfg_data_sz = 3'(dsz); cfg_slot_en = en; cfg_fs_inv = inv; cfg_mono = mono;
        case (dsz) 2: dw = 8; 3: dw = 10; 4: dw = 16; 5: dw = 20; 6: dw = 24; default: dw = 32; endcase
        sw = (ssz == 0) ? dw : (ssz == 1) ? 16 : 32;
        fl = sw * (sm1 + 1);
        act_len = (fmt >= 3) ? 1 : fl / 2;
        early = (fmt == 0) || (fmt == 3);
        off = (fmt == 2) ? sw - dw : 0;
        all = '0;
        for (int i = 0; i <= sm1; i++) all[i] = 1'b1;
        em = (en == '0) ? all : (en & all);
        src_on = 1'b1;
        run = 1'b1;
        repeat (3) @(negedge clk);
        k = 0; cur = '0;
        for (int t = 0; t < 1 + nfr * fl; t++) begin
            bclk_en = 1'b1;
            @(negedge clk);
            bclk_en = 1'b0;
            p = (t == 0) ? fl - 1 : (t - 1) % fl;
            s = p / sw; b = p % sw;
            hit = early ? (((p + 1) % fl) < act_len) : (p < act_len);
            e_en = (t != 0) && em[s];
            e_req = 1'b0;
            if (e_en && b == 0 && !(mono && sm1 == 1 && s == 1)) begin
                cur = sample_of(k); k++; e_req = 1'b1;
            end
            e_sdo = e_en && (b >= off) && (b < off + dw) && cur[dw - 1 - (b - off)];
            exp = {hit ^ inv, e_en, e_sdo, e_req};
            got = {fs, slot_act, sdo, req};
            // R1 R4 R5 R6 R13 frame/sync/data per tick
            check(got == exp, $sformatf("%s tick %0d {fs,act,sdo,req}", tag, t), got, exp);
            repeat (3) @(negedge clk);
        end
        // R12 samples taken match slot starts plus one prefetched entry
        check(src_idx == k + 1, {tag, " R12 samples taken"}, src_idx, k + 1);
        run = 1'b0;
        repeat (2) @(negedge clk);
        check({fs, sdo, slot_act, s_ready} == 4'b0, {tag, " stop idles"},
              {fs, sdo, slot_act, s_ready}, 0);
    endtask

    task automatic t_reset();
        do_reset();
        check({s_ready, sdo, fs, slot_act, req} == 5'b0, "R12 reset state",
              {s_ready, sdo, fs, slot_act, req}, 0);
    endtask

    task automatic t_i2s();   run_case("R5 R6 I2S 2x32 d16",      0, 1, 2, 4, 16'h0000, 1'b0, 1'b0, 2); endtask
    task automatic t_left();  run_case("R3 R6 LJ slot=data 10",   1, 1, 0, 3, 16'h0000, 1'b0, 1'b0, 2); endtask
    task automatic t_right(); run_case("R7 RJ 8 in 16",           2, 1, 1, 2, 16'h0000, 1'b0, 1'b0, 2); endtask
    task automatic t_pcm_a(); run_case("R10 R9 PCM early mask",   3, 3, 1, 4, 16'hF005, 1'b1, 1'b0, 2); endtask
    task automatic t_pcm_b(); run_case("R9 PCM late zero mask",   4, 7, 0, 2, 16'h0000, 1'b0, 1'b0, 2); endtask
    task automatic t_mono();  run_case("R11 mono duplicate",      0, 1, 2, 6, 16'h0000, 1'b0, 1'b1, 2); endtask
    task automatic t_wide();  run_case("R2 sixteen slots",        3, 15, 0, 2, 16'h0000, 1'b0, 1'b0, 2); endtask
    task automatic t_word();  run_case("R4 R1 32 in 32 LJ",       1, 0, 2, 7, 16'h0000, 1'b1, 1'b0, 3); endtask

    task automatic t_err_case(input string tag, input int fmt, input int ssz, input int dsz);
        logic seen;
        do_reset();
        cfg_fmt = 3'(fmt); cfg_slots_m1 = 4'd1; cfg_slot_sz = 2'(ssz);
        cfg_data_sz = 3'(dsz); cfg_slot_en = '0; cfg_fs_inv = 1'b0; cfg_mono = 1'b0;
        #1;
        check(cfg_err == 1'b1, {tag, " R8 cfg_err"}, cfg_err, 1);
        src_on = 1'b1;
        run = 1'b1;
        seen = 1'b0;
        for (int t = 0; t < 12; t++) begin
            bclk_en = 1'b1;
            @(negedge clk);
            bclk_en = 1'b0;
            seen = seen | s_ready | fs | sdo | slot_act | req;
            @(negedge clk);
        end
        check(seen == 1'b0, {tag, " R8 stays idle"}, seen, 0);
        check(src_idx == 0, {tag, " R8 no sample taken"}, src_idx, 0);
        run = 1'b0;
    endtask

    task automatic t_errors();
        t_err_case("data>slot", 0, 1, 7);
        t_err_case("bad format", 5, 2, 4);
        t_err_case("bad slot size", 1, 3, 4);
        t_err_case("bad data size", 1, 2, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_i2s();
        t_left();
        t_right();
        t_pcm_a();
        t_pcm_b();
        t_mono();
        t_wide();
        t_word();
        t_errors();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule